// File: doc/BRIEF.md
# Posted Write Sequencer with Bounded Retry

This block steers posted writes from a 64-bit local bus into a 32-bit PCI initiator through a word-wide buffer FIFO. Each accepted 64-bit beat is pushed into the FIFO as two 32-bit words. The sequencer decides when the initiator may start, how many words it is to send, and what happens when the target answers with a retry or an abort. The FIFO storage and the PCI signalling sit outside the block. The block sees the FIFO only through an occupancy count, and it sees the PCI side only through a command strobe and three response strobes.

A non-burst write goes out as a one-word or two-word transfer, depending on which halves of the double word carry enabled bytes. A burst write streams until it ends: the initiator is started once the FIFO holds the trigger number of words, or once the local burst ends if that comes first. Only one posted write can be in flight at a time. Until it retires, any new local request is answered with a rearbitrate. A target retry re-issues the command automatically, up to a set number of attempts in total. When every attempt has been used, the write is dropped and an interrupt strobe fires.

Top module: `pws_post_seq`

## Requirements
- R1: A beat is pushed (`fifo_load` high) in every cycle in which `lw_req` and `lw_dec_ok` are both high, the sequencer is able to take data, and there is room. With `lw_dec_ok` low there is neither a push nor a rearbitrate.
- R2: The usable capacity is the FIFO depth, 2^FIFO_AW words, minus three. A beat is pushed only when `fifo_occ + 2` does not exceed that capacity. Otherwise `lw_wait` is raised and nothing is pushed.
- R3: A non-burst beat (`lw_burst` low) whose enabled bytes fall in one 32-bit half only gives a command with `ini_wcnt` = 1 in the cycle after the push. Bits 3:0 of `lw_be` belong to the low word and bits 7:4 to the high word. An all-zero enable is treated as one word.
- R4: A non-burst beat with enabled bytes in both halves gives a command with `ini_wcnt` = 2.
- R5: A burst gives a command with `ini_wcnt` = 0 (stream until the burst ends). The command is raised in the cycle after the first cycle in which either the occupancy reaches TRIG_WORDS while beats are being collected, or a beat flagged `lw_last` is pushed. Beats of the open burst keep being pushed after the command.
- R6: While a write is pending and no burst is open, a valid request gets `lw_rearb` and is not pushed.
- R7: A `ini_retry` response re-raises the command in the following cycle, as long as fewer than MAX_TRY commands have been issued for this write.
- R8: A retry on attempt MAX_TRY raises `irq_retry_out` in that same cycle, and no further command is issued.
- R9: One cycle after a completion, an abort or an exhausted retry, `fifo_flush` is high for exactly one cycle. The block is idle after that.
- R10: `ini_tabort` raises `irq_tabort` in that same cycle and ends the write without issuing another command.
- R11: The attempt count starts from zero for each new write. A write that follows an exhausted one again gets MAX_TRY attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lw_req | input | 1 | Local write beat request |
| lw_dec_ok | input | 1 | Address decode valid for the beat |
| lw_burst | input | 1 | Beat belongs to a burst |
| lw_last | input | 1 | Final beat of the local write |
| lw_be | input | 8 | Byte enables of the 64-bit beat |
| fifo_occ | input | FIFO_AW+1 | FIFO occupancy in 32-bit words |
| fifo_load | output | 1 | Push the beat (two words) into the FIFO |
| fifo_flush | output | 1 | Discard the FIFO contents |
| lw_wait | output | 1 | Beat held back for lack of room |
| lw_rearb | output | 1 | Rearbitrate: write refused while one is pending |
| ini_cmd_valid | output | 1 | Start a PCI write |
| ini_wcnt | output | 2 | Word count: 1, 2, or 0 for streaming |
| ini_done | input | 1 | PCI write completed |
| ini_retry | input | 1 | Target answered with retry |
| ini_tabort | input | 1 | Target answered with abort |
| irq_retry_out | output | 1 | Retry attempts exhausted |
| irq_tabort | output | 1 | Target abort seen |

## Verification
The assertions assume that the three response strobes are one-hot, that they arrive only after a command and after any burst has ended, and that `fifo_occ` follows the block's own pushes and flushes. The bench meets these assumptions in two ways. It models the occupancy itself, adding two words per push and clearing on a flush, and it overrides the count only for the room sweep, where no push is allowed to complete. It also drives a response only once a burst's last beat has been taken and the command has been seen.

// File: rtl/pws_pkg.sv
// Shared types for the posted write sequencer.
package pws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_ISSUE   = 3'd2,
        ST_WAIT    = 3'd3,
        ST_FLUSH   = 3'd4
    } pws_state_t;
endpackage

// File: rtl/pws_intake.sv
// Beat intake: decides push, stall or rearbitrate for a local beat and
// counts the 32-bit halves that carry enabled bytes.
// Assumes fifo_occ is in words and that each beat occupies two words.
module pws_intake #(
    parameter int FIFO_AW = 4
) (
    input  logic               lw_req,
    input  logic               lw_dec_ok,
    input  logic [7:0]         lw_be,
    input  logic [FIFO_AW:0]   fifo_occ,
    input  logic               can_take,
    output logic               take,
    output logic               stall,
    output logic               rearb,
    output logic [1:0]         half_cnt
);
    localparam int DEPTH  = 1 << FIFO_AW;
    localparam int USABLE = DEPTH - 3;

    logic valid_beat;
    logic has_room;

    // Room and acceptance decision for the current beat.
    always_comb begin
        valid_beat = lw_req && lw_dec_ok;
        has_room   = ({1'b0, fifo_occ} + (FIFO_AW+2)'(2)) <= (FIFO_AW+2)'(USABLE);
        take       = valid_beat && can_take && has_room;
        stall      = valid_beat && can_take && !has_room;
        rearb      = valid_beat && !can_take;
    end

    // Word count of a non-burst beat: two when both halves carry bytes.
    always_comb begin
        if ((|lw_be[3:0]) && (|lw_be[7:4])) half_cnt = 2'd2;
        else                                half_cnt = 2'd1;
    end
endmodule

// File: rtl/pws_retry_ctl.sv
// Attempt counter: counts commands issued for the current write and reports
// when the last permitted attempt has been used. Cleared while idle.
module pws_retry_ctl #(
    parameter int MAX_TRY = 3,
    localparam int TRY_W  = $clog2(MAX_TRY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic             last_try,
    output logic [TRY_W-1:0] tries
);
    // Attempt count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) tries <= '0;
        else if (bump)       tries <= tries + TRY_W'(1);
    end

    assign last_try = tries >= TRY_W'(MAX_TRY);

    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_W'(MAX_TRY)); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tries == '0)); // R11
endmodule

// File: rtl/pws_post_seq.sv
// Posted write sequencer: collects local write beats into the buffer FIFO,
// starts the PCI initiator, reissues on retry up to MAX_TRY attempts and
// flushes on completion, abort or exhaustion.
// Assumes one-hot responses arriving only after a command and after the
// local burst has ended; fifo_occ tracks pushes and flushes.
module pws_post_seq #(
    parameter int FIFO_AW    = 4,
    parameter int TRIG_WORDS = 8,
    parameter int MAX_TRY    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lw_req,
    input  logic               lw_dec_ok,
    input  logic               lw_burst,
    input  logic               lw_last,
    input  logic [7:0]         lw_be,
    input  logic [FIFO_AW:0]   fifo_occ,
    output logic               fifo_load,
    output logic               fifo_flush,
    output logic               lw_wait,
    output logic               lw_rearb,
    output logic               ini_cmd_valid,
    output logic [1:0]         ini_wcnt,
    input  logic               ini_done,
    input  logic               ini_retry,
    input  logic               ini_tabort,
    output logic               irq_retry_out,
    output logic               irq_tabort
);
    import pws_pkg::*;

    localparam int OCC_W  = FIFO_AW + 1;
    localparam int USABLE = (1 << FIFO_AW) - 3;
    localparam int TRY_W  = $clog2(MAX_TRY + 1);

    pws_state_t       state, state_nx;
    logic             local_open;
    logic [1:0]       wcnt_q;
    logic             can_take, take, stall, rearb;
    logic [1:0]       half_cnt;
    logic             last_try;
    logic [TRY_W-1:0] tries;
    logic             trig_hit;

    // Data may enter while idle or while a burst is still open.
    assign can_take = (state == ST_IDLE) || local_open;

    pws_intake #(.FIFO_AW(FIFO_AW)) intake_i (
        .lw_req    (lw_req),
        .lw_dec_ok (lw_dec_ok),
        .lw_be     (lw_be),
        .fifo_occ  (fifo_occ),
        .can_take  (can_take),
        .take      (take),
        .stall     (stall),
        .rearb     (rearb),
        .half_cnt  (half_cnt)
    );

    pws_retry_ctl #(.MAX_TRY(MAX_TRY)) retry_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_IDLE),
        .bump     (state == ST_ISSUE),
        .last_try (last_try),
        .tries    (tries)
    );

    assign trig_hit = fifo_occ >= OCC_W'(TRIG_WORDS);

    // Next-state selection of the write sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (take) state_nx = (lw_burst && !lw_last) ? ST_COLLECT : ST_ISSUE;
            ST_COLLECT: if ((take && lw_last) || trig_hit) state_nx = ST_ISSUE;
            ST_ISSUE:   state_nx = ST_WAIT;
            ST_WAIT: begin
                if (ini_done || ini_tabort)          state_nx = ST_FLUSH;
                else if (ini_retry)                  state_nx = last_try ? ST_FLUSH : ST_ISSUE;
            end
            ST_FLUSH:   state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State, open-burst flag and word count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            local_open <= 1'b0;
            wcnt_q     <= 2'd0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && take) begin
                wcnt_q     <= lw_burst ? 2'd0 : half_cnt;
                local_open <= lw_burst && !lw_last;
            end else if (state == ST_FLUSH) begin
                local_open <= 1'b0;
            end else if (take && lw_last) begin
                local_open <= 1'b0;
            end
        end
    end

    // Output decode.
    always_comb begin
        fifo_load     = take;
        lw_wait       = stall;
        lw_rearb      = rearb;
        fifo_flush    = (state == ST_FLUSH);
        ini_cmd_valid = (state == ST_ISSUE);
        ini_wcnt      = wcnt_q;
        irq_retry_out = (state == ST_WAIT) && ini_retry && !ini_done && !ini_tabort && last_try;
        irq_tabort    = (state == ST_WAIT) && ini_tabort;
    end

    AST_LOAD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_load |-> ({1'b0, fifo_occ} + (OCC_W+1)'(2)) <= (OCC_W+1)'(USABLE)); // R2
    AST_NO_LOAD_REARB: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_load && lw_rearb)); // R6
    AST_NB_WCNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ini_cmd_valid) && $past(fifo_load) && !$past(local_open) && (ini_wcnt != 2'd0)
        |-> (ini_wcnt == 2'd1 || ini_wcnt == 2'd2)); // R3
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ini_cmd_valid |=> !ini_cmd_valid); // R7
    AST_RETRY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_retry_out |=> (fifo_flush && !ini_cmd_valid)); // R8
    AST_TABORT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tabort |=> (fifo_flush && !ini_cmd_valid)); // R10
    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush); // R9
endmodule

// File: tb/pws_post_seq_tb_top.sv
`timescale 1ns/1ps
module pws_post_seq_tb_top;
    localparam int FIFO_AW    = 4;
    localparam int TRIG_WORDS = 8;
    localparam int MAX_TRY    = 3;
    localparam int USABLE     = (1 << FIFO_AW) - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lw_req = 0, lw_dec_ok = 0, lw_burst = 0, lw_last = 0;
    logic [7:0] lw_be = 8'h00;
    logic [FIFO_AW:0] fifo_occ;
    logic fifo_load, fifo_flush, lw_wait, lw_rearb, ini_cmd_valid;
    logic [1:0] ini_wcnt;
    logic ini_done = 0, ini_retry = 0, ini_tabort = 0;
    logic irq_retry_out, irq_tabort;

    int checks = 0;
    int errors = 0;
    int model_occ = 0;
    bit occ_force = 0;
    int occ_force_val = 0;

    always #2.5 clk = ~clk;

    assign fifo_occ = occ_force ? (FIFO_AW+1)'(occ_force_val) : (FIFO_AW+1)'(model_occ);

    // Occupancy model: two words per push, cleared by a flush.
    always @(posedge clk) begin
        if (!rst_n || fifo_flush) model_occ <= 0;
        else if (fifo_load)       model_occ <= model_occ + 2;
    end

    pws_post_seq #(.FIFO_AW(FIFO_AW), .TRIG_WORDS(TRIG_WORDS), .MAX_TRY(MAX_TRY)) dut_i (
        .clk(clk), .rst_n(rst_n), .lw_req(lw_req), .lw_dec_ok(lw_dec_ok),
        .lw_burst(lw_burst), .lw_last(lw_last), .lw_be(lw_be), .fifo_occ(fifo_occ),
        .fifo_load(fifo_load), .fifo_flush(fifo_flush), .lw_wait(lw_wait),
        .lw_rearb(lw_rearb), .ini_cmd_valid(ini_cmd_valid), .ini_wcnt(ini_wcnt),
        .ini_done(ini_done), .ini_retry(ini_retry), .ini_tabort(ini_tabort),
        .irq_retry_out(irq_retry_out), .irq_tabort(irq_tabort)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One non-burst beat; returns with the sequencer in its issue cycle.
    task automatic nb_beat(input logic [7:0] be);
        @(negedge clk);
        lw_req = 1; lw_dec_ok = 1; lw_burst = 0; lw_last = 1; lw_be = be;
        #1 chk(fifo_load == 1'b1, "R1 push", fifo_load, 1);
        @(negedge clk);
        lw_req = 0; lw_last = 0;
        #1;
    endtask

    // Drive one response strobe in the wait cycle; sample irqs in it.
    task automatic respond(input int kind, output logic irq_r, output logic irq_a);
        @(negedge clk);
        ini_done = (kind == 0); ini_retry = (kind == 1); ini_tabort = (kind == 2);
        #1 irq_r = irq_retry_out; irq_a = irq_tabort;
        @(negedge clk);
        ini_done = 0; ini_retry = 0; ini_tabort = 0;
        #1;
    endtask

    // Non-burst write answered by k retries (then done if attempts remain).
    task automatic retry_run(input int k, input string tag);
        logic ir, ia;
        int cmds;
        bit ended;
        cmds = 0; ended = 0;
        nb_beat(8'h0F);
        if (ini_cmd_valid) cmds++;
        for (int r = 0; r < k && !ended; r++) begin
            respond(1, ir, ia);
            if (cmds >= MAX_TRY) begin
                chk(ir == 1'b1, {tag, " R8 irq on last attempt"}, ir, 1);
                chk(fifo_flush == 1'b1 && !ini_cmd_valid, {tag, " R9 flush after exhaust"}, fifo_flush, 1);
                ended = 1;
            end else begin
                chk(ir == 1'b0, {tag, " R7 no irq early"}, ir, 0);
                chk(ini_cmd_valid == 1'b1, {tag, " R7 reissue"}, ini_cmd_valid, 1);
                if (ini_cmd_valid) cmds++;
            end
        end
        if (!ended) begin
            respond(0, ir, ia);
            chk(ir == 1'b0, {tag, " R7 no irq on done"}, ir, 0);
            chk(fifo_flush == 1'b1, {tag, " R9 flush after done"}, fifo_flush, 1);
        end
        chk(cmds == ((k >= MAX_TRY) ? MAX_TRY : k + 1), {tag, " R7 command count"},
            cmds, (k >= MAX_TRY) ? MAX_TRY : k + 1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ir, ia;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        // Reset state
        chk(!ini_cmd_valid && !fifo_load && !fifo_flush && !lw_rearb && !irq_retry_out,
            "R9 reset idle", ini_cmd_valid, 0);

        // R1: invalid decode neither pushes nor rearbitrates
        @(negedge clk);
        lw_req = 1; lw_dec_ok = 0; lw_burst = 0; lw_last = 1; lw_be = 8'hFF;
        #1 chk(!fifo_load && !lw_rearb, "R1 decode invalid", fifo_load, 0);
        @(negedge clk) lw_req = 0;
        #1 chk(!ini_cmd_valid, "R1 no command after invalid decode", ini_cmd_valid, 0);

        // R2: room sweep with forced occupancy, beat never committed
        for (int o = 0; o <= 16; o++) begin
            @(negedge clk);
            occ_force = 1; occ_force_val = o;
            lw_req = 1; lw_dec_ok = 1; lw_burst = 0; lw_last = 1; lw_be = 8'h01;
            #1;
            chk(fifo_load == (o + 2 <= USABLE), "R2 room push", fifo_load, (o + 2 <= USABLE));
            chk(lw_wait == !(o + 2 <= USABLE), "R2 room wait", lw_wait, !(o + 2 <= USABLE));
            lw_req = 0;
        end
        @(negedge clk) occ_force = 0;
        #1 chk(!ini_cmd_valid, "R2 sweep left block idle", ini_cmd_valid, 0);

        // R3/R4: every byte-enable pattern
        for (int b = 0; b < 256; b++) begin
            int exp_w;
            exp_w = ((b & 8'h0F) != 0 && (b & 8'hF0) != 0) ? 2 : 1;
            nb_beat(8'(b));
            chk(ini_cmd_valid == 1'b1, "R3 command after beat", ini_cmd_valid, 1);
            chk(ini_wcnt == 2'(exp_w), exp_w == 2 ? "R4 two words" : "R3 one word", ini_wcnt, exp_w);
            respond(0, ir, ia);
            chk(fifo_flush == 1'b1, "R9 flush after done", fifo_flush, 1);
            @(negedge clk);
            #1 chk(!fifo_flush && !ini_cmd_valid, "R9 idle after flush", fifo_flush, 0);
        end

        // R6: rearbitrate while pending
        nb_beat(8'hF0);
        @(negedge clk);
        lw_req = 1; lw_dec_ok = 1; lw_burst = 0; lw_last = 1;
        #1 chk(lw_rearb == 1'b1 && !fifo_load, "R6 rearbitrate while pending", lw_rearb, 1);
        lw_req = 0;
        respond(0, ir, ia);
        chk(fifo_flush == 1'b1, "R9 flush after done", fifo_flush, 1);

        // R5: burst lengths 1..6, trigger vs burst end
        for (int len = 1; len <= 6; len++) begin
            int first, loads, exp_first;
            logic [1:0] w;
            first = -1; loads = 0; w = 2'd3;
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                lw_req = 1; lw_dec_ok = 1; lw_burst = 1; lw_last = (i == len - 1); lw_be = 8'hFF;
                #1;
                if (fifo_load) loads++;
                if (ini_cmd_valid && first < 0) begin first = i; w = ini_wcnt; end
            end
            @(negedge clk);
            lw_req = 0; lw_burst = 0; lw_last = 0;
            #1;
            if (ini_cmd_valid && first < 0) begin first = len; w = ini_wcnt; end
            exp_first = ((TRIG_WORDS / 2 < len - 1) ? TRIG_WORDS / 2 : len - 1) + 1;
            chk(first == exp_first, "R5 start cycle", first, exp_first);
            chk(w == 2'd0, "R5 streaming count", w, 0);
            chk(loads == len, "R5 beats pushed", loads, len);
            respond(0, ir, ia);
            chk(fifo_flush == 1'b1, "R9 flush after burst", fifo_flush, 1);
        end

        // R7/R8: retry sweep
        for (int k = 0; k <= MAX_TRY + 1; k++) retry_run(k, "retry");

        // R11: fresh write after an exhausted one gets all attempts
        retry_run(MAX_TRY, "r11_exhaust");
        retry_run(MAX_TRY - 1, "R11 fresh");

        // R10: target abort
        nb_beat(8'h3C);
        respond(2, ir, ia);
        chk(ia == 1'b1, "R10 abort irq", ia, 1);
        chk(ir == 1'b0, "R10 no retry irq", ir, 0);
        chk(fifo_flush == 1'b1 && !ini_cmd_valid, "R10 no reissue", ini_cmd_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule